// File: doc/BRIEF.md
# Four-Stage Pipelined Toy Processor Core

This block is a small in-order processor core. Its pipeline has four stages: fetch, decode, execute and writeback. A register sits between each pair of adjacent stages. The core has no functional inputs other than clock and reset. Its program lives in a constant instruction memory that is set by a parameter. Its state is eight 8-bit registers, which are preloaded from a parameter when reset is applied. A combinational debug port reads any register, and this is how results leave the core.

Three instructions are supported: a two-operand register add, a left shift by an immediate, and an unconditional jump that uses page-relative (pseudo-direct) addressing. Decode resolves the jump and discards the one instruction that was fetched in its shadow.

Two paths keep back-to-back dependent instructions correct without stalls:
- A forwarding path feeds the execute-to-writeback result back into execute.
- The register file passes a value being written through to any read of the same register in the same cycle.

A small fetch state machine tracks whether the fetch-to-decode register holds a live instruction. Its states are:
- `FS_BOOT`: empty after reset.
- `FS_RUN`: live.
- `FS_FLUSH`: a bubble left by a jump.

Its transitions are:
- BOOT to RUN on the first edge.
- RUN to FLUSH when a jump is decoded.
- FLUSH to RUN on the next edge.
- RUN stays in RUN otherwise.

Top module: `toy_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), every register holds its `REG_INIT` byte (register i at bits [8i+7:8i]), the program counter is 0 and all pipeline registers are empty. No register changes before the fourth rising edge after reset is released.
- R2: Opcode bits [7:6]=00 is add. It sets register rd (bits [5:3]) to rd + rs (rs is bits [2:0]), modulo 256.
- R3: Opcode 01 is shift-left. It sets register rd to rd shifted left by the 3-bit amount in bits [2:0], and zeros fill from the right.
- R4: Opcode 10 is jump and writes no register. The next program counter is the top 2 bits of (jump address + 1) followed by instruction bits [5:0].
- R5: A jump costs exactly one fetch slot. The instruction that follows a jump in memory is never executed.
- R6: An instruction fetched in cycle t (counted from 0 at the first edge after reset release) writes its register at rising edge t+4. Sequential fetch advances the program counter by 1 per cycle.
- R7: When the execute-to-writeback entry writes register k, execute uses that entry's result for any register operand with index k. For add this is rd or rs; for shift it is rd only. An entry that writes no register forwards nothing.
- R8: A decode-stage read of the register being written back in the same cycle returns the new value.
- R9: Instruction memory is built from `PROG`, a list of {address, instruction} 16-bit pairs, where entry i sits at bits [16i+15:16i]. Unlisted addresses read 0x00. Opcode 11 writes nothing.
- R10: `dbg_data` shows, combinationally, the committed contents of register `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 8 | Committed value of the selected register |

## Verification
The directed program places two adds to the same register back to back. A core that forwarded only on the source index would lose the first increment. An add that reads a register shifted one cycle earlier checks source forwarding. An add two slots behind its producer checks the register-file write-through; without it the add would pick up the stale pre-write value. A jump whose successor address crosses into the next 64-byte page checks pseudo-direct addressing, which would otherwise land in the wrong page. Adds planted in jump shadows and an opcode-11 word whose fields name the same register as the next add catch a missing flush or a forward from a non-writing entry. Either fault would show up as a corrupted register. Per-cycle debug reads, sampled against an independent cycle model, catch any result that commits one cycle early or late, and a mid-run reset confirms the preload.

// File: rtl/toy_core_pkg.sv
`timescale 1ns/1ps
package toy_core_pkg;
    localparam int XLEN  = 8;
    localparam int NREG  = 8;
    localparam int RIDX  = $clog2(NREG);
    localparam int OPW   = XLEN - 2 * RIDX;
    localparam int TGTW  = XLEN - OPW;
    localparam int PAGEW = XLEN - TGTW;
    localparam int PENTW = 2 * XLEN;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 2'b00,
        OP_SLL = 2'b01,
        OP_JMP = 2'b10,
        OP_NOP = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        FS_BOOT  = 2'd0,
        FS_RUN   = 2'd1,
        FS_FLUSH = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic alu_src;
        logic alu_op;
        logic reg_write;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [RIDX-1:0]  rd;
        logic [RIDX-1:0]  rs;
        logic [XLEN-1:0]  val_d;
        logic [XLEN-1:0]  val_s;
    } idex_t;

    typedef struct packed {
        logic             reg_write;
        logic [RIDX-1:0]  rd;
        logic [XLEN-1:0]  result;
    } exwb_t;

    function automatic ctrl_t ctrl_of(input opcode_e op);
        ctrl_t c;
        c = '0;
        unique case (op)
            OP_ADD: c = '{alu_src: 1'b0, alu_op: 1'b0, reg_write: 1'b1};
            OP_SLL: c = '{alu_src: 1'b1, alu_op: 1'b1, reg_write: 1'b1};
            OP_JMP: c = '0;
            OP_NOP: c = '0;
            default: c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tc_fetch.sv
`timescale 1ns/1ps
module tc_fetch
    import toy_core_pkg::*;
#(
    parameter int                       PROG_N = 1,
    parameter logic [PENTW*PROG_N-1:0]  PROG   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect,
    input  logic [XLEN-1:0]  redirect_pc,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  ifid_instr,
    output logic [PAGEW-1:0] ifid_page,
    output logic             ifid_valid,
    output fetch_state_e     state
);
    fetch_state_e    state_q, state_n;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_plus1;
    logic [XLEN-1:0] fetched;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_BOOT;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FS_BOOT:  state_n = FS_RUN;
            FS_RUN:   state_n = redirect ? FS_FLUSH : FS_RUN;
            FS_FLUSH: state_n = FS_RUN;
            default:  state_n = FS_BOOT;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        ifid_valid = (state_q == FS_RUN);
        state      = state_q;
    end

    // Constant instruction memory: later list entries win, unlisted reads zero
    always_comb begin
        fetched = '0;
        for (int i = 0; i < PROG_N; i++) begin
            if (PROG[PENTW*i+XLEN +: XLEN] == pc_q)
                fetched = PROG[PENTW*i +: XLEN];
        end
    end

    assign pc_plus1 = XLEN'(pc_q + 1'b1);
    assign pc       = pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= '0;
            ifid_instr <= '0;
            ifid_page  <= '0;
        end else begin
            pc_q       <= redirect ? redirect_pc : pc_plus1;
            ifid_instr <= fetched;
            ifid_page  <= pc_plus1[XLEN-1 -: PAGEW];
        end
    end
endmodule

// File: rtl/tc_regfile.sv
`timescale 1ns/1ps
module tc_regfile
    import toy_core_pkg::*;
#(
    parameter logic [NREG*XLEN-1:0] REG_INIT = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [RIDX-1:0]           ra_a,
    input  logic [RIDX-1:0]           ra_b,
    output logic [XLEN-1:0]           rd_a,
    output logic [XLEN-1:0]           rd_b,
    input  logic                      we,
    input  logic [RIDX-1:0]           wa,
    input  logic [XLEN-1:0]           wd,
    output logic [NREG-1:0][XLEN-1:0] state
);
    logic [NREG-1:0][XLEN-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs_q     <= REG_INIT;
        else if (we) regs_q[wa] <= wd;
    end

    // Write-through so a same-cycle read sees the value being written
    assign rd_a  = (we && wa == ra_a) ? wd : regs_q[ra_a];
    assign rd_b  = (we && wa == ra_b) ? wd : regs_q[ra_b];
    assign state = regs_q;
endmodule

// File: rtl/tc_exec.sv
`timescale 1ns/1ps
module tc_exec
    import toy_core_pkg::*;
(
    input  idex_t idex,
    input  exwb_t wb_q,
    output exwb_t wb_d
);
    logic            fwd_d, fwd_s;
    logic [XLEN-1:0] op_a, op_b, src_b;

    assign fwd_d = wb_q.reg_write && (wb_q.rd == idex.rd);
    assign fwd_s = wb_q.reg_write && !idex.ctrl.alu_src && (wb_q.rd == idex.rs);

    assign op_a  = fwd_d ? wb_q.result : idex.val_d;
    assign op_b  = fwd_s ? wb_q.result : idex.val_s;
    assign src_b = idex.ctrl.alu_src ? XLEN'(idex.rs) : op_b;

    always_comb begin
        wb_d.reg_write = idex.ctrl.reg_write;
        wb_d.rd        = idex.rd;
        wb_d.result    = idex.ctrl.alu_op ? XLEN'(op_a << src_b) : XLEN'(op_a + src_b);
    end
endmodule

// File: rtl/toy_core.sv
`timescale 1ns/1ps
module toy_core
    import toy_core_pkg::*;
#(
    parameter int                      PROG_N   = 16,
    parameter logic [PENTW*PROG_N-1:0] PROG     = {
        16'h4936, 16'h4888, 16'h4737, 16'h463F, 16'h45FF, 16'h4036, 16'h3F85, 16'h3E79,
        16'h0736, 16'h06BE, 16'h0529, 16'h0423, 16'h030B, 16'h025A, 16'h0110, 16'h0010},
    parameter logic [NREG*XLEN-1:0]    REG_INIT = {8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] dbg_sel,
    output logic [XLEN-1:0] dbg_data
);
    logic [XLEN-1:0]           pc;
    logic [XLEN-1:0]           ifid_instr;
    logic [PAGEW-1:0]          ifid_page;
    logic                      ifid_valid;
    fetch_state_e              fetch_state;
    logic                      jump_taken;
    logic [XLEN-1:0]           redirect_pc;
    opcode_e                   dec_op;
    ctrl_t                     dec_ctrl;
    logic [RIDX-1:0]           dec_rd, dec_rs;
    logic [XLEN-1:0]           rf_a, rf_b;
    logic [NREG-1:0][XLEN-1:0] rf_state;
    idex_t                     idex_q, idex_d;
    exwb_t                     exwb_q, exwb_d;

    tc_fetch #(.PROG_N(PROG_N), .PROG(PROG)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect    (jump_taken),
        .redirect_pc (redirect_pc),
        .pc          (pc),
        .ifid_instr  (ifid_instr),
        .ifid_page   (ifid_page),
        .ifid_valid  (ifid_valid),
        .state       (fetch_state)
    );

    // Decode
    assign dec_op      = opcode_e'(ifid_instr[XLEN-1 -: OPW]);
    assign dec_rd      = ifid_instr[2*RIDX-1 -: RIDX];
    assign dec_rs      = ifid_instr[RIDX-1:0];
    assign dec_ctrl    = ifid_valid ? ctrl_of(dec_op) : '0;
    assign jump_taken  = ifid_valid && (dec_op == OP_JMP);
    assign redirect_pc = {ifid_page, ifid_instr[TGTW-1:0]};

    tc_regfile #(.REG_INIT(REG_INIT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (dec_rd),
        .ra_b  (dec_rs),
        .rd_a  (rf_a),
        .rd_b  (rf_b),
        .we    (exwb_q.reg_write),
        .wa    (exwb_q.rd),
        .wd    (exwb_q.result),
        .state (rf_state)
    );

    always_comb begin
        idex_d.ctrl  = dec_ctrl;
        idex_d.rd    = dec_rd;
        idex_d.rs    = dec_rs;
        idex_d.val_d = rf_a;
        idex_d.val_s = rf_b;
    end

    tc_exec u_exec (
        .idex (idex_q),
        .wb_q (exwb_q),
        .wb_d (exwb_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idex_q <= '0;
            exwb_q <= '0;
        end else begin
            idex_q <= idex_d;
            exwb_q <= exwb_d;
        end
    end

    assign dbg_data = rf_state[dbg_sel];
endmodule

// File: rtl/tc_core_checks.sv
`timescale 1ns/1ps
module tc_core_checks
    import toy_core_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input fetch_state_e              fs,
    input logic [XLEN-1:0]           pc,
    input logic                      jump_taken,
    input logic [XLEN-1:0]           redirect_pc,
    input logic                      idex_we,
    input logic                      wb_we,
    input logic [RIDX-1:0]           wb_rd,
    input logic [XLEN-1:0]           wb_data,
    input logic [NREG-1:0][XLEN-1:0] rf_state
);
    a_r1_boot_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fs == FS_BOOT) |=> (fs == FS_RUN));

    a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        jump_taken |=> (pc == $past(redirect_pc)));

    a_r5_flush_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
        jump_taken |=> (fs == FS_FLUSH));

    a_r5_no_write_from_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (fs != FS_RUN) |=> !idex_we);

    a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !jump_taken |=> (pc == XLEN'($past(pc) + 1'b1)));

    a_r10_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |=> (rf_state[$past(wb_rd)] == $past(wb_data)));
endmodule

bind toy_core tc_core_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs          (fetch_state),
    .pc          (pc),
    .jump_taken  (jump_taken),
    .redirect_pc (redirect_pc),
    .idex_we     (idex_q.ctrl.reg_write),
    .wb_we       (exwb_q.reg_write),
    .wb_rd       (exwb_q.rd),
    .wb_data     (exwb_q.result),
    .rf_state    (rf_state)
);

// File: tb/tb_toy_core.sv
`timescale 1ns/1ps
module tb_toy_core;
    localparam int N    = 16;
    localparam int MAXE = 80;
    // {address, instruction} pairs; entry 0 in the low bits
    localparam logic [16*N-1:0] TB_PROG = {
        16'h4936, 16'h4888, 16'h4737, 16'h463F, 16'h45FF, 16'h4036, 16'h3F85, 16'h3E79,
        16'h0736, 16'h06BE, 16'h0529, 16'h0423, 16'h030B, 16'h025A, 16'h0110, 16'h0010};
    localparam logic [63:0] TB_INIT = {8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dbg_sel = '0;
    logic [7:0] dbg_data;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    logic       sch_v   [0:MAXE];
    logic [2:0] sch_rd  [0:MAXE];
    logic [7:0] sch_val [0:MAXE];
    logic [7:0] exp_r   [0:7];

    always #5 clk = ~clk;

    toy_core #(.PROG_N(N), .PROG(TB_PROG), .REG_INIT(TB_INIT)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data)
    );

    function automatic logic [7:0] prog_at(input logic [7:0] a);
        logic [7:0] v = 8'h00;  // R9: unlisted reads zero
        for (int i = 0; i < N; i++)
            if (TB_PROG[16*i+8 +: 8] == a) v = TB_PROG[16*i +: 8];
        return v;
    endfunction

    // Architectural model with fetch-slot timing: commit at edge t+4 (R6)
    task automatic build_sched();
        logic [7:0] r [0:7];
        logic [7:0] pc = 8'h00;
        logic [7:0] ins, nxt;
        int t = 0;
        for (int i = 0; i < 8; i++) r[i] = TB_INIT[8*i +: 8];
        for (int e = 0; e <= MAXE; e++) begin
            sch_v[e] = 1'b0; sch_rd[e] = '0; sch_val[e] = '0;
        end
        while (t + 4 <= MAXE) begin
            ins = prog_at(pc);
            nxt = 8'(pc + 1);
            case (ins[7:6])
                2'b00: begin  // R2 add
                    r[ins[5:3]] = 8'(r[ins[5:3]] + r[ins[2:0]]);
                    sch_v[t+4] = 1'b1; sch_rd[t+4] = ins[5:3]; sch_val[t+4] = r[ins[5:3]];
                    pc = nxt; t++;
                end
                2'b01: begin  // R3 shift
                    r[ins[5:3]] = 8'(r[ins[5:3]] << ins[2:0]);
                    sch_v[t+4] = 1'b1; sch_rd[t+4] = ins[5:3]; sch_val[t+4] = r[ins[5:3]];
                    pc = nxt; t++;
                end
                2'b10: begin  // R4 jump, R5 one lost slot
                    pc = {nxt[7:6], ins[5:0]};
                    t = t + 2;
                end
                default: begin pc = nxt; t++; end
            endcase
        end
    endtask

    task automatic reset_exp();
        for (int i = 0; i < 8; i++) exp_r[i] = TB_INIT[8*i +: 8];
    endtask

    task automatic check_reg(input int idx, input string tag);
        dbg_sel = 3'(idx);
        #0.2;
        n_run++;
        if (dbg_data !== exp_r[idx]) begin
            n_fail++;
            $display("FAIL %s: register %0d actual %0d expected %0d", tag, idx, dbg_data, exp_r[idx]);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 8; i++) check_reg(i, tag);
    endtask

    task automatic run_edges(input int n, input int sweep_upto);
        for (int e = 1; e <= n; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (sch_v[e]) exp_r[sch_rd[e]] = sch_val[e];
            if (e <= sweep_upto) sweep("R6 timing");
            else check_reg(int'($urandom % 8), "R10 R6 debug read");
        end
    endtask

    initial begin
        string tags [0:7];
        tags = '{"R9 noop", "R7 rs forward", "R2 R7 rd forward", "R3 shift",
                 "R8 write-through", "R8 write-through", "R5 flush", "R4 page jump"};
        void'($urandom(32'h5eed_1234));
        build_sched();
        reset_exp();
        repeat (3) @(posedge clk);
        @(negedge clk);
        sweep("R1 reset preload");
        rst_n = 1'b1;
        run_edges(MAXE, 14);
        for (int i = 0; i < 8; i++) check_reg(i, tags[i]);
        // Reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        reset_exp();
        sweep("R1 reset reload");
        rst_n = 1'b1;
        run_edges(20, 20);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule